// File: doc/BRIEF.md
# Four-Channel Complex Sample Block Buffer

This block gathers complex samples (separate 24-bit I and Q halves) coming from up to four resampler channels and groups them into blocks of four complex words. A finished block is copied into a bank that a host processor reads through a small register window. Each read word carries the sample value, rounded to the selected output width, in its upper three bytes. The lowest byte is always zero.

Two fill policies are available. In arrival order, the next four complex samples fill slots 0 to 3 in the order they come in. In channel-slotted order, the channel number picks the slot. Arrival of channel 0's Q half closes the block that is being collected.

The host and the block share a handshake. The host sets READY when it has finished reading. A completed block is accepted only while READY is set, and accepting it clears READY. A block that completes without READY is dropped and raises a sticky MISSED flag. An optional strobe on `rdy_o` announces each accepted block. The strobe's polarity and length are programmable.

Top module: `iq_blkbuf`

## Requirements
- R1: After reset, READY and MISSED read 0, and `rdy_o` sits at its idle level (0, because the control register resets to all zeros).
- R2: Writing status address 1 with bit 0 = 1 sets READY. Accepting a block into the read bank clears READY.
- R3: When a block completes while READY is clear, the block is dropped and the read bank is unchanged. MISSED then becomes 1 and stays 1 until a write to address 1 with bit 1 = 1 clears it.
- R4: If the write that sets READY falls in the same cycle as a block completion, the block is accepted. READY ends at 0 and MISSED is not set.
- R5: Arrival order (control bit 2 = 0): successive complex samples fill slots 0, 1, 2, 3, whatever their channel. The block completes on the fourth Q half.
- R6: Channel-slotted order (control bit 2 = 1): channel c is written to slot c. A Q half from channel 0 closes the block held so far, provided that block holds any data. The new channel-0 sample then starts the next block. Slots of channels that sent nothing read zero.
- R7: An I half (`s_qhalf` = 0) is held until the next Q half, and the two are stored together as one complex word.
- R8: Read address bit 3 = 0 selects a data word. Address bits 2:1 give the slot and bit 0 the half (0 = I, 1 = Q). The value is in bits 31:8, and bits 7:0 are 0. Address bit 3 = 1 returns {MISSED, READY} in bits 1:0.
- R9: Control bits 1:0 select the output width: 0 = 24, 1 = 20, 2 = 16, 3 = 12 bits. The value is rounded half-up on the dropped bits, and those bits read zero. The width applies at read time to the held bank.
- R10: Rounding that would pass the positive full scale saturates to the largest positive value of the chosen width.
- R11: With control bit 3 set, `rdy_o` takes its active level in the cycle after a block is accepted and holds it for (control bits 8:5) + 1 cycles. Control bit 4 inverts the output. With bit 3 clear, `rdy_o` stays at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample half valid |
| s_chan | input | 2 | Channel number of the half |
| s_qhalf | input | 1 | 1 = Q half, 0 = I half |
| s_data | input | 24 | Signed sample half |
| h_wr | input | 1 | Host register write strobe |
| h_waddr | input | 1 | 0 = control register, 1 = status (set READY / clear MISSED) |
| h_wdata | input | 9 | Host write data |
| h_raddr | input | 4 | Host read address |
| h_rdata | output | 32 | Host read data (combinational) |
| rdy_o | output | 1 | Block-ready strobe |

## Verification
Two events can land in the same cycle: a block completion and the host write that sets READY. The bench lines up the fourth Q half of an arrival-order block with a status write of bit 0 in that one cycle. It judges the outcome at the ports. The status must then read zero (READY consumed, MISSED clear), the strobe must run its programmed length, and the window must hold the new block rather than the old one.

// File: rtl/iq_blkbuf_pkg.sv
package iq_blkbuf_pkg;
  localparam int SW = 24;

  typedef struct packed {
    logic [SW-1:0] i;
    logic [SW-1:0] q;
  } cword_t;

  // Round half-up into the upper bits for the selected width, saturate
  // positive overflow, clear the dropped bits.
  function automatic logic [SW-1:0] round_to(input logic [SW-1:0] x,
                                             input logic [1:0] wsel);
    logic [SW-1:0] mask;
    logic [SW-1:0] half;
    logic [SW:0]   s;
    logic [SW-1:0] r;
    case (wsel)
      2'd1:    begin mask = SW'(24'h00000F); half = SW'(24'h000008); end
      2'd2:    begin mask = SW'(24'h0000FF); half = SW'(24'h000080); end
      2'd3:    begin mask = SW'(24'h000FFF); half = SW'(24'h000800); end
      default: begin mask = '0;              half = '0;              end
    endcase
    s = {x[SW-1], x} + {1'b0, half};
    if (s[SW] != s[SW-1]) r = {1'b0, {(SW-1){1'b1}}} & ~mask;
    else                  r = s[SW-1:0] & ~mask;
    return r;
  endfunction
endpackage

// File: rtl/iq_blkbuf_fill.sv
module iq_blkbuf_fill
  import iq_blkbuf_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = $clog2(NCH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chan_mode,
  input  logic                s_valid,
  input  logic [CW-1:0]       s_chan,
  input  logic                s_qhalf,
  input  logic [SW-1:0]       s_data,
  output logic                blk_done,
  output cword_t [NCH-1:0]    blk_out
);
  logic [SW-1:0]    pend_i;
  cword_t [NCH-1:0] fill, merged;
  logic [CW-1:0]    wptr, slot;
  logic             has_data;
  logic             q_evt;
  cword_t           word;

  assign q_evt = s_valid & s_qhalf;
  assign word  = '{i: pend_i, q: s_data};
  assign slot  = chan_mode ? s_chan : wptr;

  always_comb begin
    merged       = fill;
    merged[slot] = word;
  end

  assign blk_done = q_evt & (chan_mode ? ((s_chan == '0) & has_data)
                                       : (wptr == CW'(NCH-1)));
  assign blk_out  = chan_mode ? fill : merged;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_i   <= '0;
      fill     <= '0;
      wptr     <= '0;
      has_data <= 1'b0;
    end else begin
      if (s_valid && !s_qhalf) pend_i <= s_data;
      if (q_evt) begin
        if (blk_done) begin
          fill <= '0;
          wptr <= '0;
          if (chan_mode) begin
            fill[0]  <= word;
            has_data <= 1'b1;
          end else begin
            has_data <= 1'b0;
          end
        end else begin
          fill[slot] <= word;
          has_data   <= 1'b1;
          if (!chan_mode) wptr <= wptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/iq_blkbuf_hs.sv
module iq_blkbuf_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic set_rdy,
  input  logic clr_miss,
  input  logic blk_done,
  output logic ready,
  output logic missed,
  output logic blk_xfer,
  output logic blk_drop
);
  assign blk_xfer = blk_done & (ready | set_rdy);
  assign blk_drop = blk_done & ~blk_xfer;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      missed <= 1'b0;
    end else begin
      if (blk_xfer)     ready <= 1'b0;
      else if (set_rdy) ready <= 1'b1;
      if (blk_drop)      missed <= 1'b1;
      else if (clr_miss) missed <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_blkbuf_pulse.sv
module iq_blkbuf_pulse #(
  parameter int LW = 4,
  localparam int CNW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [LW-1:0] len_m1,
  input  logic          en,
  input  logic          inv,
  output logic          pin
);
  logic [CNW-1:0] cnt;
  logic           active;

  assign active = (cnt != '0);
  assign pin    = (en & active) ^ inv;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (fire)   cnt <= {1'b0, len_m1} + CNW'(1);
    else if (active) cnt <= cnt - CNW'(1);
  end
endmodule

// File: rtl/iq_blkbuf.sv
module iq_blkbuf
  import iq_blkbuf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int LW  = 4,
  localparam int CW  = $clog2(NCH),
  localparam int AW  = CW + 2,
  localparam int CTW = LW + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  input  logic [CW-1:0]  s_chan,
  input  logic           s_qhalf,
  input  logic [SW-1:0]  s_data,
  input  logic           h_wr,
  input  logic           h_waddr,
  input  logic [CTW-1:0] h_wdata,
  input  logic [AW-1:0]  h_raddr,
  output logic [31:0]    h_rdata,
  output logic           rdy_o
);
  logic [CTW-1:0]   ctl;
  logic [1:0]       ctl_wsel;
  logic             ctl_chan, ctl_en, ctl_inv;
  logic [LW-1:0]    ctl_len;
  logic             set_rdy, clr_miss;
  logic             blk_done, blk_xfer, blk_drop;
  logic             st_ready, st_missed;
  cword_t [NCH-1:0] blk_out, bank;
  cword_t           rd_word;
  logic [SW-1:0]    rd_half;

  assign ctl_wsel = ctl[1:0];
  assign ctl_chan = ctl[2];
  assign ctl_en   = ctl[3];
  assign ctl_inv  = ctl[4];
  assign ctl_len  = ctl[CTW-1:5];

  assign set_rdy  = h_wr & h_waddr & h_wdata[0];
  assign clr_miss = h_wr & h_waddr & h_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n)                  ctl <= '0;
    else if (h_wr && !h_waddr)   ctl <= h_wdata;
  end

  iq_blkbuf_fill #(.NCH(NCH)) u_fill (
    .clk(clk), .rst_n(rst_n), .chan_mode(ctl_chan),
    .s_valid(s_valid), .s_chan(s_chan), .s_qhalf(s_qhalf), .s_data(s_data),
    .blk_done(blk_done), .blk_out(blk_out)
  );

  iq_blkbuf_hs u_hs (
    .clk(clk), .rst_n(rst_n), .set_rdy(set_rdy), .clr_miss(clr_miss),
    .blk_done(blk_done), .ready(st_ready), .missed(st_missed),
    .blk_xfer(blk_xfer), .blk_drop(blk_drop)
  );

  iq_blkbuf_pulse #(.LW(LW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(blk_xfer), .len_m1(ctl_len),
    .en(ctl_en), .inv(ctl_inv), .pin(rdy_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        bank <= '0;
    else if (blk_xfer) bank <= blk_out;
  end

  assign rd_word = bank[h_raddr[AW-2:1]];
  assign rd_half = h_raddr[0] ? rd_word.q : rd_word.i;

  always_comb begin
    if (h_raddr[AW-1]) h_rdata = {30'd0, st_missed, st_ready};
    else               h_rdata = {round_to(rd_half, ctl_wsel), 8'h00};
  end
endmodule

// File: rtl/iq_blkbuf_chk.sv
module iq_blkbuf_chk #(
  parameter int BW = 192
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_done,
  input logic          blk_xfer,
  input logic          set_rdy,
  input logic          clr_miss,
  input logic          ready,
  input logic          missed,
  input logic          rdy_o,
  input logic          rdy_en,
  input logic          rdy_inv,
  input logic          stat_sel,
  input logic [7:0]    rd_lsb,
  input logic [BW-1:0] bank
);
  p_xfer_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_xfer |=> !ready);
  p_set_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_rdy && !blk_done |=> ready);
  p_miss_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && !ready && !set_rdy |=> missed);
  p_miss_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    missed && !clr_miss |=> missed);
  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_xfer |=> $stable(bank));
  p_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done && set_rdy && !missed |=> !missed && !ready);
  p_lsb_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_sel |-> rd_lsb == 8'h00);
  p_pulse_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    blk_xfer && rdy_en && $stable(rdy_en) |=> rdy_o != rdy_inv);
endmodule

bind iq_blkbuf iq_blkbuf_chk #(.BW(NCH*2*iq_blkbuf_pkg::SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_done(blk_done), .blk_xfer(blk_xfer),
  .set_rdy(set_rdy), .clr_miss(clr_miss), .ready(st_ready),
  .missed(st_missed), .rdy_o(rdy_o), .rdy_en(ctl_en), .rdy_inv(ctl_inv),
  .stat_sel(h_raddr[AW-1]), .rd_lsb(h_rdata[7:0]), .bank(bank)
);

// File: tb/sim_iq_blkbuf.sv
`timescale 1ns/1ps
module sim_iq_blkbuf;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic [1:0]  s_chan = '0;
  logic        s_qhalf = 1'b0;
  logic [23:0] s_data = '0;
  logic        h_wr = 1'b0;
  logic        h_waddr = 1'b0;
  logic [8:0]  h_wdata = '0;
  logic [3:0]  h_raddr = '0;
  logic [31:0] h_rdata;
  logic        rdy_o;

  int n_chk = 0;
  int n_bad = 0;
  int cur_w = 24;
  logic [23:0] expq[$];
  logic [23:0] mdl_bank[8];

  always #2 clk = ~clk;

  iq_blkbuf u0 (.*);

  function automatic logic [23:0] mdl_round(logic [23:0] x, int w);
    int d, v, t, hi;
    d = 24 - w;
    if (d == 0) return x;
    v = $signed({{8{x[23]}}, x});
    t = v + (1 << (d - 1));
    t = (t >>> d) <<< d;
    hi = (1 << 23) - (1 << d);
    if (t > hi) t = hi;
    return t[23:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [8:0] d);
    h_wr = 1'b1; h_waddr = a; h_wdata = d;
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic ctl(logic [8:0] d, int w);
    wr(1'b0, d);
    cur_w = w;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    h_raddr = a;
    #0.5;
    d = h_rdata;
  endtask

  task automatic push(logic [1:0] ch, logic [23:0] i, logic [23:0] q, bit set_too);
    s_valid = 1'b1; s_chan = ch; s_qhalf = 1'b0; s_data = i;
    @(negedge clk);
    s_qhalf = 1'b1; s_data = q;
    if (set_too) begin h_wr = 1'b1; h_waddr = 1'b1; h_wdata = 9'd1; end
    @(negedge clk);
    s_valid = 1'b0; s_qhalf = 1'b0; h_wr = 1'b0;
  endtask

  task automatic exp_word(logic [23:0] i, logic [23:0] q);
    expq.push_back(i);
    expq.push_back(q);
  endtask

  // monitor side: take one accepted block from the scoreboard queue
  task automatic take_block(string req);
    for (int k = 0; k < 8; k++) begin
      if (expq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s: scoreboard empty, got %h expected %h", req, 0, 1);
        return;
      end
      mdl_bank[k] = expq.pop_front();
    end
  endtask

  task automatic cmp_window(string req);
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      rd(4'(k), d);
      chk(req, d, {mdl_round(mdl_bank[k], cur_w), 8'h00});
    end
  endtask

  task automatic pulse_len(logic idle, output int n);
    n = 0;
    while (rdy_o !== idle && n < 40) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic status(string req, logic [31:0] exp);
    logic [31:0] d;
    rd(4'h8, d);
    chk(req, d, exp);
  endtask

  initial begin
    int n;
    logic [31:0] d;
    bit quiet;
    for (int k = 0; k < 8; k++) mdl_bank[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    status("R1", 32'd0);
    chk("R1 rdy idle", {31'd0, rdy_o}, 32'd0);
    cmp_window("R1 bank zero");

    // arrival order, 24-bit, strobe on, 3 cycles
    ctl(9'h048, 24);
    wr(1'b1, 9'd1);
    status("R2 set", 32'd1);
    push(2'd0, 24'h123456, 24'hFEDCBA, 0); exp_word(24'h123456, 24'hFEDCBA);
    push(2'd1, 24'h7FFFF0, 24'h800000, 0); exp_word(24'h7FFFF0, 24'h800000);
    push(2'd2, 24'h000080, 24'hFFFF7F, 0); exp_word(24'h000080, 24'hFFFF7F);
    push(2'd3, 24'h0ABCDE, 24'h00000F, 0); exp_word(24'h0ABCDE, 24'h00000F);
    pulse_len(1'b0, n);
    chk("R11 pulse length 3", n, 3);
    status("R2 cleared on accept", 32'd0);
    take_block("R5");
    cmp_window("R5 R7 arrival fill");
    rd(4'h1, d);
    chk("R8 Q half slot0", d, 32'hFEDCBA00);

    // widths applied at read
    ctl(9'h04A, 16);
    cmp_window("R9 16-bit");
    rd(4'h2, d);
    chk("R10 saturation", d, 32'h7FFF0000);
    rd(4'h4, d);
    chk("R9 half-up 16", d, 32'h00010000);
    ctl(9'h04B, 12);
    cmp_window("R9 12-bit");
    ctl(9'h049, 20);
    cmp_window("R9 20-bit");
    ctl(9'h048, 24);

    // drop while READY clear
    push(2'd0, 24'h111111, 24'h222222, 0);
    push(2'd1, 24'h333333, 24'h444444, 0);
    push(2'd2, 24'h555555, 24'h666666, 0);
    push(2'd3, 24'h777777, 24'h888888, 0);
    chk("R3 no strobe on drop", {31'd0, rdy_o}, 32'd0);
    status("R3 missed set", 32'd2);
    cmp_window("R3 bank kept");
    wr(1'b1, 9'd0);
    status("R3 sticky", 32'd2);
    wr(1'b1, 9'd2);
    status("R3 cleared", 32'd0);

    // channel-slotted order, inverted 1-cycle strobe
    ctl(9'h01C, 24);
    chk("R11 inverted idle", {31'd0, rdy_o}, 32'd1);
    wr(1'b1, 9'd1);
    push(2'd0, 24'h0A0001, 24'h0A0002, 0);
    push(2'd1, 24'h0B0001, 24'h0B0002, 0);
    push(2'd3, 24'h0D0001, 24'h0D0002, 0);
    status("R6 still open", 32'd1);
    push(2'd0, 24'h0A0011, 24'h0A0012, 0);
    exp_word(24'h0A0001, 24'h0A0002); exp_word(24'h0B0001, 24'h0B0002);
    exp_word(24'h0, 24'h0);           exp_word(24'h0D0001, 24'h0D0002);
    pulse_len(1'b1, n);
    chk("R11 inverted length 1", n, 1);
    status("R2 chan accept", 32'd0);
    take_block("R6");
    cmp_window("R6 slotted block");
    wr(1'b1, 9'd1);
    push(2'd2, 24'h0C0021, 24'h0C0022, 0);
    push(2'd0, 24'h0A0031, 24'h0A0032, 0);
    exp_word(24'h0A0011, 24'h0A0012); exp_word(24'h0, 24'h0);
    exp_word(24'h0C0021, 24'h0C0022); exp_word(24'h0, 24'h0);
    take_block("R6");
    cmp_window("R6 idle channels zero");

    // READY set in the completing cycle
    ctl(9'h048, 24);
    push(2'd3, 24'h010101, 24'h020202, 0); exp_word(24'h010101, 24'h020202);
    push(2'd2, 24'h030303, 24'h040404, 0); exp_word(24'h030303, 24'h040404);
    push(2'd1, 24'h050505, 24'h060606, 0); exp_word(24'h050505, 24'h060606);
    push(2'd0, 24'h070707, 24'h080808, 1); exp_word(24'h070707, 24'h080808);
    pulse_len(1'b0, n);
    chk("R4 strobe on collision", n, 3);
    status("R4 ready consumed, no miss", 32'd0);
    take_block("R4");
    cmp_window("R4 new block taken");

    // strobe disabled
    ctl(9'h040, 24);
    wr(1'b1, 9'd1);
    quiet = 1'b1;
    push(2'd0, 24'hF00001, 24'hF00002, 0); exp_word(24'hF00001, 24'hF00002);
    push(2'd1, 24'hF00003, 24'hF00004, 0); exp_word(24'hF00003, 24'hF00004);
    push(2'd2, 24'hF00005, 24'hF00006, 0); exp_word(24'hF00005, 24'hF00006);
    push(2'd3, 24'hF00007, 24'hF00008, 0); exp_word(24'hF00007, 24'hF00008);
    for (int k = 0; k < 4; k++) begin
      if (rdy_o !== 1'b0) quiet = 1'b0;
      @(negedge clk);
    end
    chk("R11 disabled stays idle", {31'd0, quiet}, 32'd1);
    status("R2 accepted while disabled", 32'd0);
    take_block("R5");
    cmp_window("R5 negative values");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule